// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects a single-clock host request port to an external 32K x 8 asynchronous static RAM. The host offers a request with a valid/ready handshake. Each request carries a read/write flag, a 15-bit word address and, for writes, an 8-bit data byte. The controller then sequences the memory strobes. These are active-low chip select, output enable and write enable. It also drives a registered address bus and a data bus that is split into an output byte, an input byte and a drive enable for the pad tri-state.

Each access is timed by clock-cycle counts that are set as parameters, so the memory's minimum AC times can be met for the chosen clock and speed grade. The defaults suit a 100 MHz clock and a 25 ns part: three access cycles for a read, one address/data setup cycle before write enable falls, two cycles of write-enable pulse, and two idle turnaround cycles after a read. Turnaround covers the time the memory may keep driving the bus after output enable rises.

A write ends on the rising edge of write enable. Chip select, address and data are all held one cycle past that edge. Output enable stays high for the whole write, so only one side ever drives the data bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it is released: chip select, output enable and write enable are high, the data drive enable is low, ready is high and the response valid is low.
- R2: With no request offered, chip select stays high, the bus is not driven and ready stays high.
- R3: A read holds chip select and output enable low and write enable high for exactly RD_WAIT cycles, starting the cycle after acceptance. The address stays equal to the accepted one even if the host inputs change.
- R4: Read data is the byte the memory presents during the last access cycle. It is returned with a response valid that is high for exactly one cycle, the cycle right after the last access cycle.
- R5: After a read there are TURN_IDLE cycles in which all strobes are high, the bus is not driven and ready is low. A request held valid through them is accepted on the first ready cycle.
- R6: A write proceeds in this order. First, WR_SETUP cycles with chip select low, write enable high and the bus driven. Then WR_PULSE cycles with write enable low. Then one cycle with write enable high while chip select stays low and the bus is still driven. After that, chip select rises and the drive is released.
- R7: Output enable is high throughout a write. The drive enable is never high while output enable is low.
- R8: During a write, the address bus carries the accepted address and the data output carries the accepted byte, unchanged from setup to release.
- R9: Ready is low from the cycle after acceptance until the access, including any turnaround, has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
A behavioural memory model answers reads only while chip select and output enable are low, and it returns a marker value at other times. If the design samples on the wrong edge, it therefore returns the marker rather than the data. The bench uses writes of all-zero, all-one and alternating bytes at the lowest, highest and mixed addresses, and reads each one back. These separate a correct strobe sequence from one whose pulse never reaches the array. One read is followed by a write request held valid through the access, which shows that the latched address does not follow the host and that the turnaround is kept before the bus is driven. Back-to-back writes and reads of untouched locations show that a write only updates its own address.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int RD_WAIT   = 3,
  parameter int WR_SETUP  = 1,
  parameter int WR_PULSE  = 2,
  parameter int TURN_IDLE = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int M1   = (RD_WAIT > WR_SETUP) ? RD_WAIT : WR_SETUP;
  localparam int M2   = (WR_PULSE > TURN_IDLE) ? WR_PULSE : TURN_IDLE;
  localparam int MAXW = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXW + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSU, S_WPL, S_WHD, S_TURN} st_t;

  st_t           st, nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          last;

  assign last      = (cnt == '0);
  assign req_ready = (st == S_IDLE);

  always_comb begin
    nx     = st;
    cnt_nx = last ? cnt : cnt - 1'b1;
    case (st)
      S_IDLE: begin
        cnt_nx = cnt;
        if (req_valid) begin
          nx     = req_write ? S_WSU : S_RD;
          cnt_nx = req_write ? CW'(WR_SETUP - 1) : CW'(RD_WAIT - 1);
        end
      end
      S_RD:   if (last) begin nx = S_TURN; cnt_nx = CW'(TURN_IDLE - 1); end
      S_WSU:  if (last) begin nx = S_WPL;  cnt_nx = CW'(WR_PULSE - 1); end
      S_WPL:  if (last) begin nx = S_WHD;  cnt_nx = '0; end
      S_WHD:  nx = S_IDLE;
      S_TURN: if (last) nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      st        <= nx;
      cnt       <= cnt_nx;
      mem_cs_n  <= !(nx inside {S_RD, S_WSU, S_WPL, S_WHD});
      mem_oe_n  <= (nx != S_RD);
      mem_we_n  <= (nx != S_WPL);
      mem_dq_oe <= (nx inside {S_WSU, S_WPL, S_WHD});
      rsp_valid <= (st == S_RD) && last;
      if ((st == S_RD) && last) rsp_rdata <= mem_dq_in;
      if ((st == S_IDLE) && req_valid) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
    end
  end

  logic [CW-1:0] since_oe;
  always_ff @(posedge clk) begin
    if (rst)                              since_oe <= CW'(TURN_IDLE);
    else if (!mem_oe_n)                   since_oe <= '0;
    else if (since_oe != CW'(TURN_IDLE))  since_oe <= since_oe + 1'b1;
  end

  AST_WE_UNDER_CS:    assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> !mem_cs_n);             // R6
  AST_WE_RISE_HELD:   assert property (@(posedge clk) disable iff (rst) $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe)); // R6
  AST_NO_DRIVE_FIGHT: assert property (@(posedge clk) disable iff (rst) mem_dq_oe |-> mem_oe_n);               // R7
  AST_WR_STABLE:      assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R8
  AST_RSP_ONE:        assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid);            // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst) !mem_cs_n |-> !req_ready);            // R9
  AST_TURN_GAP:       assert property (@(posedge clk) disable iff (rst) mem_dq_oe |-> (since_oe == CW'(TURN_IDLE))); // R5

endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
  localparam int AW = 15, DW = 8, RD_WAIT = 3, WR_SETUP = 1, WR_PULSE = 2, TURN_IDLE = 2;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem [256];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sram_async_ctrl #(.AW(AW), .DW(DW), .RD_WAIT(RD_WAIT), .WR_SETUP(WR_SETUP),
                    .WR_PULSE(WR_PULSE), .TURN_IDLE(TURN_IDLE)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h3C;
    end else if (!mem_cs_n && !mem_we_n) begin
      mem[mem_addr[7:0]] <= mem_dq_out;
    end
  end

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ? mem[mem_addr[7:0]] : 8'hEE;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) step();
    chk("R1", "cs_n in reset", mem_cs_n, 1);
    chk("R1", "oe_n in reset", mem_oe_n, 1);
    chk("R1", "we_n in reset", mem_we_n, 1);
    chk("R1", "dq_oe in reset", mem_dq_oe, 0);
    rst = 0;
    step();
    chk("R1", "ready after reset", req_ready, 1);
    chk("R1", "rsp_valid after reset", rsp_valid, 0);
    chk("R1", "cs_n after reset", mem_cs_n, 1);
  endtask

  task automatic t_idle();
    req_valid = 0;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R2", "cs_n idle", mem_cs_n, 1);
      chk("R2", "dq_oe idle", mem_dq_oe, 0);
      chk("R2", "ready idle", req_ready, 1);
    end
  endtask

  task automatic wr_body(input logic [AW-1:0] a, input logic [DW-1:0] d);
    for (int k = 0; k < WR_SETUP; k++) begin
      chk("R6", "setup cs_n", mem_cs_n, 0);
      chk("R6", "setup we_n", mem_we_n, 1);
      chk("R6", "setup dq_oe", mem_dq_oe, 1);
      chk("R7", "setup oe_n", mem_oe_n, 1);
      chk("R8", "setup addr", mem_addr, a);
      chk("R8", "setup data", mem_dq_out, d);
      chk("R9", "setup ready", req_ready, 0);
      step();
    end
    for (int k = 0; k < WR_PULSE; k++) begin
      chk("R6", "pulse we_n", mem_we_n, 0);
      chk("R6", "pulse cs_n", mem_cs_n, 0);
      chk("R7", "pulse oe_n", mem_oe_n, 1);
      chk("R8", "pulse addr", mem_addr, a);
      chk("R8", "pulse data", mem_dq_out, d);
      chk("R9", "pulse ready", req_ready, 0);
      step();
    end
    chk("R6", "hold we_n", mem_we_n, 1);
    chk("R6", "hold cs_n", mem_cs_n, 0);
    chk("R6", "hold dq_oe", mem_dq_oe, 1);
    chk("R8", "hold data", mem_dq_out, d);
    chk("R9", "hold ready", req_ready, 0);
    step();
    chk("R6", "release cs_n", mem_cs_n, 1);
    chk("R6", "release dq_oe", mem_dq_oe, 0);
    chk("R9", "ready after write", req_ready, 1);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    chk("R9", "ready before write", req_ready, 1);
    step();
    req_valid = 0; req_addr = ~a; req_wdata = ~d;
    wr_body(a, d);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input bit hold,
                        input logic [AW-1:0] na, input logic [DW-1:0] nd);
    req_valid = 1; req_write = 0; req_addr = a;
    chk("R9", "ready before read", req_ready, 1);
    step();
    if (hold) begin req_write = 1; req_addr = na; req_wdata = nd; end
    else req_valid = 0;
    for (int k = 0; k < RD_WAIT; k++) begin
      chk("R3", "read cs_n", mem_cs_n, 0);
      chk("R3", "read oe_n", mem_oe_n, 0);
      chk("R3", "read we_n", mem_we_n, 1);
      chk("R3", "read addr", mem_addr, a);
      chk("R7", "read dq_oe", mem_dq_oe, 0);
      chk("R9", "read ready", req_ready, 0);
      chk("R4", "early rsp_valid", rsp_valid, 0);
      step();
    end
    chk("R4", "rsp_valid", rsp_valid, 1);
    chk("R4", "rsp_rdata", rsp_rdata, exp);
    for (int k = 0; k < TURN_IDLE; k++) begin
      chk("R5", "turn ready", req_ready, 0);
      chk("R5", "turn cs_n", mem_cs_n, 1);
      chk("R5", "turn oe_n", mem_oe_n, 1);
      chk("R5", "turn dq_oe", mem_dq_oe, 0);
      step();
      if (k == 0) chk("R4", "rsp_valid one cycle", rsp_valid, 0);
    end
    chk("R5", "ready after turn", req_ready, 1);
    if (hold) begin
      step();
      req_valid = 0;
      wr_body(na, nd);
    end
  endtask

  initial begin
    t_reset();
    t_idle();
    t_read(15'h0000, 8'h3C, 0, '0, '0);
    t_write(15'h7FFF, 8'hA5);
    t_read(15'h7FFF, 8'hA5, 0, '0, '0);
    t_write(15'h0000, 8'h00);
    t_read(15'h0000, 8'h00, 0, '0, '0);
    t_write(15'h2A5A, 8'hFF);
    t_read(15'h2A5A, 8'hFF, 0, '0, '0);
    t_read(15'h1234, 8'h08, 1, 15'h4081, 8'h5A);
    t_read(15'h4081, 8'h5A, 0, '0, '0);
    t_write(15'h0011, 8'h55);
    t_write(15'h0012, 8'hAA);
    t_read(15'h0011, 8'h55, 0, '0, '0);
    t_read(15'h0012, 8'hAA, 0, '0, '0);
    t_read(15'h0013, 8'h13 ^ 8'h3C, 0, '0, '0);
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule